// File: doc/BRIEF.md
# Last-Target Indirect Branch Predictor

This block predicts where an indirect branch will jump by remembering the most recent target that was seen for branches at the same table slot. The table is direct-mapped and has no tags. A slot is chosen by a group of instruction-address bits that sit just above the alignment bits, which are always zero. Each request carries a branch address and the target that branch actually resolved to. One cycle later the block returns the target it had stored, together with a flag that says whether that stored target differs from the real one.

Every request overwrites its slot with the actual target, whether the prediction was right or wrong. Branches whose addresses select the same slot share that slot silently, by design. Reset clears every slot to zero, so a slot that has never been written predicts target zero. Back-to-back requests work at full rate: a request always compares against everything written by the requests before it, including the request in the cycle just before.

Top module: `itgt_pred`

## Requirements
- R1: While reset is held and on the first cycle after it, `res_valid`, `pred_target` and `mispredict` are 0. Reset also clears every slot to 0, so the first request to any slot after reset returns `pred_target` = 0.
- R2: `res_valid` is 1 in exactly the cycle after a cycle in which `req_valid` was 1, and 0 otherwise.
- R3: The slot index is `br_addr[ALIGN_LSB + IDX_W - 1 : ALIGN_LSB]`, which is bits [10:2] with the default values. Address bits below and above that field have no effect on which slot is used.
- R4: `pred_target` is the target stored in the indexed slot, and `mispredict` is 1 exactly when that value differs from the request's `act_target`.
- R5: Every request writes `act_target` into its slot. This happens after a correct prediction and after a mispredict alike.
- R6: Two addresses that produce the same index read and write the same slot, and no tag check is made.
- R7: When a request follows another request to the same slot in the very next cycle, it is compared against the target written by the first request.
- R8: While `req_valid` is 0, `pred_target` and `mispredict` keep their last values. The table is not changed, whatever `br_addr` and `act_target` carry.
- R9: A write to one slot does not change the content of any other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears the table |
| req_valid | input | 1 | A branch lookup and update is presented this cycle |
| br_addr | input | ADDR_W | Instruction address of the branch |
| act_target | input | ADDR_W | Resolved target of the branch |
| res_valid | output | 1 | Result of the previous cycle's request is on the outputs |
| pred_target | output | ADDR_W | Target that was stored in the slot |
| mispredict | output | 1 | Stored target differed from the actual target |

## Verification
A corrupted slot shows up at the ports on the next request that selects that slot. `pred_target` then carries the wrong value one cycle after the request, and `mispredict` takes the wrong polarity as well. A fault in the index decode or a missing write-back stays hidden until a later request revisits the slot. For this reason each scenario writes a known target and then reads it back through another request, through an alias address, or in the cycle directly after it. A wrong reset shows up on the very first request to a slot, as a nonzero `pred_target`.

// File: rtl/itgt_pred.sv
module itgt_pred #(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 9,
  parameter int ALIGN_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic [ADDR_W-1:0] act_target,
  output logic              res_valid,
  output logic [ADDR_W-1:0] pred_target,
  output logic              mispredict
);

  localparam int DEPTH = 1 << IDX_W;

  logic [ADDR_W-1:0] slot_q [DEPTH];
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] stored;

  assign idx    = br_addr[ALIGN_LSB +: IDX_W];
  assign stored = slot_q[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (req_valid) begin
      slot_q[idx] <= act_target;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      pred_target <= '0;
      mispredict  <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        pred_target <= stored;
        mispredict  <= stored != act_target;
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!res_valid && !mispredict && pred_target == '0)); // R1

  AST_RESULT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(req_valid)); // R2

  AST_FLAG_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (mispredict == (pred_target != $past(act_target)))); // R4

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(req_valid) && $past(rst_n) &&
     br_addr[ALIGN_LSB +: IDX_W] == $past(br_addr[ALIGN_LSB +: IDX_W]))
    |=> pred_target == $past(act_target, 2)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(pred_target) && $stable(mispredict))); // R8

endmodule

// File: tb/test_itgt_pred.sv
module test_itgt_pred;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] br_addr = '0;
  logic [AW-1:0] act_target = '0;
  logic          res_valid;
  logic [AW-1:0] pred_target;
  logic          mispredict;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  itgt_pred i_itgt_pred (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .br_addr(br_addr),
    .act_target(act_target), .res_valid(res_valid),
    .pred_target(pred_target), .mispredict(mispredict)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 res_valid in reset", 64'(res_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 res_valid after reset", 64'(res_valid), 64'd0);
    chk("R1 pred_target after reset", 64'(pred_target), 64'd0);
    chk("R1 mispredict after reset", 64'(mispredict), 64'd0);
  endtask

  task automatic lookup(input string rq, input logic [AW-1:0] a, input logic [AW-1:0] t,
                        input logic [AW-1:0] exp_pred);
    @(negedge clk);
    chk({rq, " R2 idle res_valid"}, 64'(res_valid), 64'd0);
    req_valid = 1'b1; br_addr = a; act_target = t;
    @(negedge clk);
    req_valid = 1'b0;
    chk({rq, " R2 res_valid"}, 64'(res_valid), 64'd1);
    chk({rq, " pred_target"}, 64'(pred_target), 64'(exp_pred));
    chk({rq, " R4 mispredict"}, 64'(mispredict), 64'(exp_pred != t));
  endtask

  task automatic t_cold_and_overwrite();
    lookup("R1 cold slot", 32'h100, 32'hAAAA_0000, 32'h0);
    lookup("R4 hit", 32'h100, 32'hAAAA_0000, 32'hAAAA_0000);
    lookup("R5 overwrite after hit", 32'h100, 32'hBBBB_0000, 32'hAAAA_0000);
    lookup("R5 overwrite after miss", 32'h100, 32'hBBBB_0000, 32'hBBBB_0000);
  endtask

  task automatic t_alias();
    lookup("R6 first", 32'h104, 32'h1111, 32'h0);
    lookup("R6 alias high bits", 32'h904, 32'h2222, 32'h1111);
    lookup("R3 low bits ignored", 32'h107, 32'h2222, 32'h2222);
    lookup("R3 top bits ignored", 32'hF000_0104, 32'h2222, 32'h2222);
  endtask

  task automatic t_indep();
    lookup("R9 neighbour slot cold", 32'h108, 32'h3333, 32'h0);
    lookup("R9 original slot kept", 32'h104, 32'h2222, 32'h2222);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    req_valid = 1'b1; br_addr = 32'h200; act_target = 32'h4444;
    @(negedge clk);
    chk("R7 first pred", 64'(pred_target), 64'd0);
    chk("R7 first mispredict", 64'(mispredict), 64'd1);
    br_addr = 32'h200; act_target = 32'h5555;
    @(negedge clk);
    chk("R7 second pred", 64'(pred_target), 64'h4444);
    chk("R7 second mispredict", 64'(mispredict), 64'd1);
    br_addr = 32'h204; act_target = 32'h6666;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 b2b other slot", 64'(pred_target), 64'd0);
    chk("R2 b2b res_valid", 64'(res_valid), 64'd1);
  endtask

  task automatic t_idle();
    @(negedge clk);
    br_addr = 32'h200; act_target = 32'h9999;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R8 idle res_valid", 64'(res_valid), 64'd0);
      chk("R8 idle pred held", 64'(pred_target), 64'd0);
      chk("R8 idle flag held", 64'(mispredict), 64'd1);
    end
    lookup("R8 idle did not write", 32'h200, 32'h5555, 32'h5555);
  endtask

  initial begin
    do_reset();
    t_cold_and_overwrite();
    t_alias();
    t_indep();
    t_back_to_back();
    t_idle();
    do_reset();
    lookup("R1 table cleared by reset", 32'h100, 32'hBBBB_0000, 32'h0);
    lookup("R1 alias slot cleared", 32'h904, 32'h1, 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule